// File: doc/BRIEF.md
# Branch Coupler Control Function Controller

This block is the command layer of a single-wire bus branch switch. A slave bit engine upstream hands it the bytes the bus master writes, marks the start and end of each byte the master reads, and reports bus resets. Out of these it decodes six control commands. It drives the connect enables and the pull-down enables of a main and an auxiliary downstream branch, and an open-drain control output. It reports branch state through a status byte.

The sensed logic level of each branch passes through a synchronizer. It feeds three things: the level bits of the status byte, the per-branch event flags, and the presence and short checks of the smart-on sequence. A smart-on command turns the next written byte into a reset-low on the chosen branch. It turns the byte read after that into the presence window of that branch. It then connects the branch, unless the branch is stuck low. A stuck-low branch is reported to the master through an inverted confirmation byte.

Top module: `branch_coupler_fn`

## Requirements
- R1: After power-on reset both branches are disconnected, no pull-down is on, the control output is off, the mode is auto and the association is main. With idle-high lines the status byte reads 0Fh.
- R2: Command 5Ah is followed by one written control byte. That byte takes effect only when its bits 4 and 3 are both 0. Every later read until the next bus reset returns the current status byte.
- R3: Status byte layout. Bit 0 is the main branch disconnected flag. Bit 1 is the main level. Bit 2 is the auxiliary disconnected flag. Bit 3 is the auxiliary level. Bit 4 is the main event flag. Bit 5 is the auxiliary event flag. Bit 6 is the control status. Bit 7 is the mode.
- R4: Control byte fields. Bit 5 is the mode (1 = manual). Bit 6 is the association (1 = auxiliary). Bit 7 is the manual value. In manual mode the control output equals the manual value and status bit 6 shows it. In auto mode status bit 6 shows the association.
- R5: In auto mode the control output is on exactly while its associated branch is connected.
- R6: A falling level on a disconnected branch sets that branch's event flag. Falls on a connected branch set nothing. Falls caused by the block's own pull-downs set nothing.
- R7: Command 66h disconnects both branches, clears both event flags and ends a discharge. It keeps the mode, association and manual value. It confirms with 66h.
- R8: Command 99h disconnects both branches and turns both pull-downs on. This holds across bus resets until another recognised command. It confirms with 99h.
- R9: Command A5h connects the main branch and disconnects the auxiliary branch, confirming A5h. The two branches are never connected at once.
- R10: Smart-on (CCh main, 33h auxiliary) disconnects the target at once. The target pull-down is on during the next written byte. The following read returns 00h if the target went low in that window, else FFh.
- R11: After the response byte, a target seen high connects the target, disconnects the other branch and confirms with the command code. A target seen low stays disconnected, the other branch is untouched, and the confirmation is the inverted code.
- R12: A bus reset during the smart-on stimulus byte releases the pull-down on the next clock. Any bus reset returns command decoding to its start.
- R13: An unrecognised command byte changes nothing, and reads return FFh until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| busReset | input | 1 | One-cycle pulse: reset seen on the upstream bus |
| wrStart | input | 1 | Pulse: first slot of a master write byte |
| wrDone | input | 1 | Pulse: master write byte complete, wrByte valid |
| wrByte | input | 8 | Byte written by the master |
| rdStart | input | 1 | Pulse: first slot of a master read byte |
| rdDone | input | 1 | Pulse: last slot of a master read byte |
| rdByte | output | 8 | Byte to send; sampled slot by slot by the bit engine |
| mainLevel | input | 1 | Sensed level of the main branch |
| auxLevel | input | 1 | Sensed level of the auxiliary branch |
| mainOn | output | 1 | Main branch connect enable |
| auxOn | output | 1 | Auxiliary branch connect enable |
| mainPull | output | 1 | Main branch pull-down enable |
| auxPull | output | 1 | Auxiliary branch pull-down enable |
| ctlOn | output | 1 | Control transistor on (conducting) |

## Verification
The status command is tried with control bytes that have bit 3 or bit 4 set and with bytes that have both clear. This separates ignored writes from applied ones. A sweep of mode, association and manual value checks that status bit 6 and the control output follow the right source. Smart-on is run three ways: with a device pulling the target low during the response byte, with a silent target, and with a target held low throughout. These separate the 00h/FFh responses and the straight or inverted confirmation, and show whether activation happened. Falls are injected on connected branches, on disconnected branches and under the block's own discharge and stimulus, so that only the genuine events set flags. A bus reset in the middle of the stimulus byte shows the pull-down release and the restart of command decoding.

// File: rtl/bcf_pkg.sv
`timescale 1ns/1ps
package bcf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CMD_STATUS    = 8'h5A;
  localparam byte_t CMD_ALL_OFF   = 8'h66;
  localparam byte_t CMD_DISCHARGE = 8'h99;
  localparam byte_t CMD_DIRECT    = 8'hA5;
  localparam byte_t CMD_SMART_MN  = 8'hCC;
  localparam byte_t CMD_SMART_AX  = 8'h33;

  localparam byte_t BYTE_RELEASED = '1;
  localparam byte_t BYTE_PRESENT  = '0;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_CFG, SEQ_STIM_WAIT, SEQ_STIM,
    SEQ_PRES_WAIT, SEQ_PRES, SEQ_REPLY, SEQ_IGNORE
  } seq_e;

  typedef struct packed {
    logic allOff;
    logic dischOn;
    logic dischOff;
    logic actMain;
    logic actAux;
    logic dropMain;
    logic dropAux;
    logic cfgWr;
    logic stimMain;
    logic stimAux;
    logic busyMain;
    logic busyAux;
  } strobe_t;
endpackage

// File: rtl/bcf_sync.sv
`timescale 1ns/1ps
module bcf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '1;
    else       shiftQ <= {shiftQ[STAGES-2:0], din};
  end

  assign dout = shiftQ[STAGES-1];
endmodule

// File: rtl/bcf_datapath.sv
`timescale 1ns/1ps
module bcf_datapath
  import bcf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:3] cfgHi,
  input  logic       mainLevel,
  input  logic       auxLevel,
  output logic       mainOn,
  output logic       auxOn,
  output logic       mainPull,
  output logic       auxPull,
  output logic       ctlOn,
  output byte_t      statusByte,
  output logic       mainLvl,
  output logic       auxLvl
);
  localparam int NBR = 2;

  logic [NBR-1:0] rawLvl, syncLvl, prevLvl;
  logic mainAct, auxAct, dischg;
  logic modeMan, assocAux, manVal;
  logic evMain, evAux;
  logic fallMain, fallAux, cfgOk;

  assign rawLvl = {auxLevel, mainLevel};

  for (genvar g = 0; g < NBR; g++) begin : g_sync
    bcf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawLvl[g]),
      .dout (syncLvl[g])
    );
  end

  assign fallMain = prevLvl[0] & ~syncLvl[0];
  assign fallAux  = prevLvl[1] & ~syncLvl[1];
  assign cfgOk    = stb.cfgWr && (cfgHi[4:3] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainAct  <= 1'b0;
      auxAct   <= 1'b0;
      dischg   <= 1'b0;
      modeMan  <= 1'b0;
      assocAux <= 1'b0;
      manVal   <= 1'b0;
      evMain   <= 1'b0;
      evAux    <= 1'b0;
      prevLvl  <= '1;
    end else begin
      prevLvl <= syncLvl;
      if (stb.allOff) begin
        mainAct <= 1'b0;
        auxAct  <= 1'b0;
        dischg  <= 1'b0;
      end else begin
        if (stb.dischOn) begin
          mainAct <= 1'b0;
          auxAct  <= 1'b0;
          dischg  <= 1'b1;
        end
        if (stb.dischOff) dischg  <= 1'b0;
        if (stb.dropMain) mainAct <= 1'b0;
        if (stb.dropAux)  auxAct  <= 1'b0;
        if (stb.actMain) begin
          mainAct <= 1'b1;
          auxAct  <= 1'b0;
        end
        if (stb.actAux) begin
          auxAct  <= 1'b1;
          mainAct <= 1'b0;
        end
      end
      if (cfgOk) begin
        modeMan  <= cfgHi[5];
        assocAux <= cfgHi[6];
        manVal   <= cfgHi[7];
      end
      if (stb.allOff) begin
        evMain <= 1'b0;
        evAux  <= 1'b0;
      end else begin
        if (fallMain && !mainAct && !mainPull && !stb.busyMain) evMain <= 1'b1;
        if (fallAux  && !auxAct  && !auxPull  && !stb.busyAux)  evAux  <= 1'b1;
      end
    end
  end

  assign mainOn   = mainAct;
  assign auxOn    = auxAct;
  assign mainPull = dischg | stb.stimMain;
  assign auxPull  = dischg | stb.stimAux;
  assign ctlOn    = modeMan ? manVal : (assocAux ? auxAct : mainAct);
  assign mainLvl  = syncLvl[0];
  assign auxLvl   = syncLvl[1];

  assign statusByte = {modeMan, (modeMan ? manVal : assocAux), evAux, evMain,
                       syncLvl[1], ~auxAct, syncLvl[0], ~mainAct};
endmodule

// File: rtl/bcf_control.sv
`timescale 1ns/1ps
module bcf_control
  import bcf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busReset,
  input  logic    wrStart,
  input  logic    wrDone,
  input  byte_t   wrByte,
  input  logic    rdStart,
  input  logic    rdDone,
  input  byte_t   statusByte,
  input  logic    mainLvl,
  input  logic    auxLvl,
  output strobe_t stb,
  output byte_t   rdByte
);
  seq_e  seqQ;
  logic  tgtAux, presSeen, confLive;
  byte_t cmdQ, confQ;
  logic  tgtLvl, inSmart;

  assign tgtLvl  = tgtAux ? auxLvl : mainLvl;
  assign inSmart = (seqQ == SEQ_STIM_WAIT) || (seqQ == SEQ_STIM) ||
                   (seqQ == SEQ_PRES_WAIT) || (seqQ == SEQ_PRES);

  always_comb begin
    stb = '0;
    stb.stimMain = (seqQ == SEQ_STIM) && !tgtAux;
    stb.stimAux  = (seqQ == SEQ_STIM) &&  tgtAux;
    stb.busyMain = inSmart && !tgtAux;
    stb.busyAux  = inSmart &&  tgtAux;
    if (!busReset) begin
      unique case (seqQ)
        SEQ_IDLE: if (wrDone) begin
          unique case (wrByte)
            CMD_STATUS:    stb.dischOff = 1'b1;
            CMD_ALL_OFF:   stb.allOff   = 1'b1;
            CMD_DISCHARGE: stb.dischOn  = 1'b1;
            CMD_DIRECT:    begin stb.dischOff = 1'b1; stb.actMain  = 1'b1; end
            CMD_SMART_MN:  begin stb.dischOff = 1'b1; stb.dropMain = 1'b1; end
            CMD_SMART_AX:  begin stb.dischOff = 1'b1; stb.dropAux  = 1'b1; end
            default: ;
          endcase
        end
        SEQ_CFG: stb.cfgWr = wrDone;
        SEQ_PRES: if (rdDone && tgtLvl) begin
          stb.actMain = !tgtAux;
          stb.actAux  =  tgtAux;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ     <= SEQ_IDLE;
      tgtAux   <= 1'b0;
      presSeen <= 1'b0;
      confLive <= 1'b0;
      cmdQ     <= '0;
      confQ    <= BYTE_RELEASED;
    end else if (busReset) begin
      seqQ     <= SEQ_IDLE;
      presSeen <= 1'b0;
    end else begin
      unique case (seqQ)
        SEQ_IDLE: if (wrDone) begin
          cmdQ     <= wrByte;
          confQ    <= wrByte;
          confLive <= 1'b0;
          unique case (wrByte)
            CMD_STATUS:                        seqQ <= SEQ_CFG;
            CMD_ALL_OFF, CMD_DISCHARGE,
            CMD_DIRECT:                        seqQ <= SEQ_REPLY;
            CMD_SMART_MN: begin tgtAux <= 1'b0; seqQ <= SEQ_STIM_WAIT; end
            CMD_SMART_AX: begin tgtAux <= 1'b1; seqQ <= SEQ_STIM_WAIT; end
            default:                           seqQ <= SEQ_IGNORE;
          endcase
        end
        SEQ_CFG: if (wrDone) begin
          confLive <= 1'b1;
          seqQ     <= SEQ_REPLY;
        end
        SEQ_STIM_WAIT: if (wrStart) seqQ <= SEQ_STIM;
        SEQ_STIM:      if (wrDone)  seqQ <= SEQ_PRES_WAIT;
        SEQ_PRES_WAIT: if (rdStart) begin
          presSeen <= 1'b0;
          seqQ     <= SEQ_PRES;
        end
        SEQ_PRES: begin
          if (!tgtLvl) presSeen <= 1'b1;
          if (rdDone) begin
            confQ <= tgtLvl ? cmdQ : ~cmdQ;
            seqQ  <= SEQ_REPLY;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (seqQ)
      SEQ_REPLY: rdByte = confLive ? statusByte : confQ;
      SEQ_PRES:  rdByte = presSeen ? BYTE_PRESENT : BYTE_RELEASED;
      default:   rdByte = BYTE_RELEASED;
    endcase
  end
endmodule

// File: rtl/branch_coupler_fn.sv
`timescale 1ns/1ps
module branch_coupler_fn
  import bcf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       wrStart,
  input  logic       wrDone,
  input  logic [7:0] wrByte,
  input  logic       rdStart,
  input  logic       rdDone,
  output logic [7:0] rdByte,
  input  logic       mainLevel,
  input  logic       auxLevel,
  output logic       mainOn,
  output logic       auxOn,
  output logic       mainPull,
  output logic       auxPull,
  output logic       ctlOn
);
  strobe_t stb;
  byte_t   statusByte;
  logic    mainLvl, auxLvl;

  bcf_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .busReset   (busReset),
    .wrStart    (wrStart),
    .wrDone     (wrDone),
    .wrByte     (wrByte),
    .rdStart    (rdStart),
    .rdDone     (rdDone),
    .statusByte (statusByte),
    .mainLvl    (mainLvl),
    .auxLvl     (auxLvl),
    .stb        (stb),
    .rdByte     (rdByte)
  );

  bcf_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgHi      (wrByte[7:3]),
    .mainLevel  (mainLevel),
    .auxLevel   (auxLevel),
    .mainOn     (mainOn),
    .auxOn      (auxOn),
    .mainPull   (mainPull),
    .auxPull    (auxPull),
    .ctlOn      (ctlOn),
    .statusByte (statusByte),
    .mainLvl    (mainLvl),
    .auxLvl     (auxLvl)
  );
endmodule

// File: rtl/bcf_checker.sv
`timescale 1ns/1ps
module bcf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busReset,
  input logic       mainOn,
  input logic       auxOn,
  input logic       mainPull,
  input logic       auxPull,
  input logic [7:0] statusByte
);
  // R9: never both branches connected
  assert_one_branch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(mainOn && auxOn));

  // R8: discharge keeps both branches disconnected
  assert_discharge_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mainPull && auxPull) |-> (!mainOn && !auxOn));

  // R10: the main pull-down never fights a connected main branch
  assert_pull_disc_R10: assert property (@(posedge clk) disable iff (!rstN)
    mainPull |-> !mainOn);

  // R12: a bus reset drops a stimulus pull-down on the next edge
  assert_reset_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !(mainPull && auxPull)) |=> (!mainPull && !auxPull));

  // R6: the main event flag rises only if main was disconnected
  assert_event_inactive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[4]) |-> !$past(mainOn));

  // R7: event flags clear only together with disconnecting both branches
  assert_event_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[4]) |-> (!mainOn && !auxOn));
endmodule

bind branch_coupler_fn bcf_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busReset   (busReset),
  .mainOn     (mainOn),
  .auxOn      (auxOn),
  .mainPull   (mainPull),
  .auxPull    (auxPull),
  .statusByte (statusByte)
);

// File: tb/test_branch_coupler_fn.sv
`timescale 1ns/1ps
module test_branch_coupler_fn;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, busReset = 1'b0;
  logic wrStart = 1'b0, wrDone = 1'b0, rdStart = 1'b0, rdDone = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic [7:0] rdByte;
  logic mainOn, auxOn, mainPull, auxPull, ctlOn;
  logic mainDevLow = 1'b0, auxDevLow = 1'b0, mainShort = 1'b0;
  logic mainLevel, auxLevel;

  assign mainLevel = !(mainPull || mainDevLow || mainShort);
  assign auxLevel  = !(auxPull || auxDevLow);

  branch_coupler_fn i_branch_coupler_fn (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .wrStart(wrStart), .wrDone(wrDone), .wrByte(wrByte),
    .rdStart(rdStart), .rdDone(rdDone), .rdByte(rdByte),
    .mainLevel(mainLevel), .auxLevel(auxLevel),
    .mainOn(mainOn), .auxOn(auxOn), .mainPull(mainPull), .auxPull(auxPull),
    .ctlOn(ctlOn)
  );

  int checks = 0, failures = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic portChk(input string tag, input logic act, input logic exp);
    @(negedge clk);
    check(tag, {7'b0, act}, {7'b0, exp});
  endtask

  // monitor: compare every byte the design returns against the scoreboard
  always @(negedge clk) begin
    if (rdDone) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL unexpected read actual=%h expected=none", rdByte);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, rdByte, e);
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic busRst;
    tick; busReset = 1'b1; tick; busReset = 1'b0;
    repeat (3) tick;
  endtask

  task automatic wrBegin;
    tick; wrStart = 1'b1; tick; wrStart = 1'b0;
    repeat (6) tick;
  endtask

  task automatic wrEnd(input logic [7:0] b);
    wrByte = b; wrDone = 1'b1; tick; wrDone = 1'b0;
    repeat (4) tick;
  endtask

  task automatic wrB(input logic [7:0] b);
    wrBegin; wrEnd(b);
  endtask

  // pullSel: 0 none, 1 main device pulls low, 2 aux device pulls low
  task automatic rdB(input logic [7:0] exp, input string tag, input int pullSel);
    expQ.push_back(exp); tagQ.push_back(tag);
    tick; rdStart = 1'b1; tick; rdStart = 1'b0;
    repeat (2) tick;
    if (pullSel == 1) mainDevLow = 1'b1;
    if (pullSel == 2) auxDevLow = 1'b1;
    repeat (8) tick;
    mainDevLow = 1'b0; auxDevLow = 1'b0;
    repeat (12) tick;
    rdDone = 1'b1; tick; rdDone = 1'b0;
    repeat (4) tick;
  endtask

  task automatic statusCmd(input logic [7:0] ctrl, input logic [7:0] exp, input string tag);
    busRst; wrB(8'h5A); wrB(ctrl);
    rdB(exp, tag, 0);
    rdB(exp, {tag, " repeat R2"}, 0);
  endtask

  task automatic pulseLow(input bit onAux);
    if (onAux) auxDevLow = 1'b1; else mainDevLow = 1'b1;
    repeat (6) tick;
    auxDevLow = 1'b0; mainDevLow = 1'b0;
    repeat (6) tick;
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    repeat (4) tick;
    rstN = 1'b1;
    repeat (4) tick;
    // R1 reset state
    portChk("R1 mainOn", mainOn, 1'b0);
    portChk("R1 auxOn", auxOn, 1'b0);
    portChk("R1 mainPull", mainPull, 1'b0);
    portChk("R1 auxPull", auxPull, 1'b0);
    portChk("R1 ctlOn", ctlOn, 1'b0);
    statusCmd(8'h18, 8'h0F, "R1 R3 status after reset, R2 guarded write");

    // R4 mode and association
    statusCmd(8'h60, 8'h8F, "R4 manual off");
    portChk("R4 ctl manual off", ctlOn, 1'b0);
    statusCmd(8'hE0, 8'hCF, "R4 manual on");
    portChk("R4 ctl manual on", ctlOn, 1'b1);
    statusCmd(8'h40, 8'h4F, "R4 auto assoc aux");
    portChk("R5 ctl auto aux idle", ctlOn, 1'b0);

    // R9 direct on
    busRst; wrB(8'hA5); rdB(8'hA5, "R9 echo", 0);
    portChk("R9 mainOn", mainOn, 1'b1);
    portChk("R9 auxOn", auxOn, 1'b0);
    portChk("R5 ctl follows aux", ctlOn, 1'b0);
    statusCmd(8'h08, 8'h4E, "R2 bit3 blocks write");
    statusCmd(8'h00, 8'h0E, "R3 R4 auto assoc main");
    portChk("R5 ctl follows main", ctlOn, 1'b1);

    // R6 events
    pulseLow(1'b0);
    busRst; wrB(8'h66); rdB(8'h66, "R7 echo", 0);
    portChk("R7 mainOn off", mainOn, 1'b0);
    portChk("R5 ctl off after drop", ctlOn, 1'b0);
    pulseLow(1'b0);
    pulseLow(1'b1);
    statusCmd(8'h18, 8'h3F, "R6 both events, none while active");
    busRst; wrB(8'h66); rdB(8'h66, "R7 echo", 0);
    statusCmd(8'h18, 8'h0F, "R7 events cleared");

    // R7 keeps mode
    statusCmd(8'hE0, 8'hCF, "R4 manual on again");
    busRst; wrB(8'h66); rdB(8'h66, "R7 echo manual", 0);
    portChk("R7 manual ctl kept", ctlOn, 1'b1);
    statusCmd(8'h18, 8'hCF, "R7 mode kept");
    statusCmd(8'h00, 8'h0F, "R4 back to auto");

    // R8 discharge
    busRst; wrB(8'h99); rdB(8'h99, "R8 echo", 0);
    portChk("R8 mainPull", mainPull, 1'b1);
    portChk("R8 auxPull", auxPull, 1'b1);
    busRst;
    portChk("R8 held over bus reset", mainPull, 1'b1);
    busRst; wrB(8'h66); rdB(8'h66, "R8 end echo", 0);
    portChk("R8 ended main", mainPull, 1'b0);
    portChk("R8 ended aux", auxPull, 1'b0);
    statusCmd(8'h18, 8'h0F, "R6 no event from discharge");

    // R10 R11 smart-on main with presence
    busRst; wrB(8'hCC);
    portChk("R10 main off after cmd", mainOn, 1'b0);
    wrBegin;
    portChk("R10 stim pull main", mainPull, 1'b1);
    portChk("R10 stim no aux pull", auxPull, 1'b0);
    wrEnd(8'hFF);
    portChk("R10 stim released", mainPull, 1'b0);
    repeat (4) tick;
    rdB(8'h00, "R10 presence seen", 1);
    rdB(8'hCC, "R11 confirm main", 0);
    portChk("R11 mainOn", mainOn, 1'b1);
    portChk("R11 auxOn", auxOn, 1'b0);
    portChk("R5 ctl main on", ctlOn, 1'b1);

    // smart-on aux without presence
    busRst; wrB(8'h33); wrB(8'hFF);
    repeat (4) tick;
    rdB(8'hFF, "R10 no presence", 0);
    rdB(8'h33, "R11 confirm aux", 0);
    portChk("R11 auxOn", auxOn, 1'b1);
    portChk("R11 main dropped", mainOn, 1'b0);
    portChk("R5 ctl off assoc main", ctlOn, 1'b0);

    // smart-on main into a short
    mainShort = 1'b1;
    busRst; wrB(8'hCC); wrB(8'hFF);
    repeat (4) tick;
    rdB(8'h00, "R10 short reads low", 0);
    rdB(8'h33, "R11 short inverted confirm", 0);
    portChk("R11 short no activation", mainOn, 1'b0);
    portChk("R11 short other kept", auxOn, 1'b1);
    mainShort = 1'b0;
    repeat (6) tick;
    busRst; wrB(8'h66); rdB(8'h66, "R7 echo", 0);

    // R12 bus reset during stimulus
    busRst; wrB(8'hCC); wrBegin;
    portChk("R12 pull before reset", mainPull, 1'b1);
    tick; busReset = 1'b1; tick; busReset = 1'b0;
    portChk("R12 pull released", mainPull, 1'b0);
    wrEnd(8'hFF);
    rdB(8'hFF, "R13 R12 restart ignores FF", 0);
    portChk("R12 main stays off", mainOn, 1'b0);

    // R13 unknown command
    busRst; wrB(8'h12); rdB(8'hFF, "R13 unknown reads FF", 0);
    portChk("R13 mainOn", mainOn, 1'b0);
    portChk("R13 auxPull", auxPull, 1'b0);
    statusCmd(8'h18, 8'h0F, "R13 status unchanged");

    repeat (4) tick;
    check("scoreboard drained", 8'(expQ.size()), 8'd0);
    summary;
    $finish;
  end
endmodule